// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This block adds or subtracts two packed floating-point words with one sign bit, an 8-bit exponent with bias 127, and a mantissa width set by a parameter. The supported layouts are 16, 24 and 32 bits, with 7, 15 or 23 mantissa bits. Addition and subtraction use the same datapath. For a subtract, the sign of the second operand is flipped before the two magnitudes are combined.

Each operand is split into sign, exponent and significand. The operand with the larger magnitude fixes the result exponent and the result sign. The other significand is shifted right into a window twice the significand width and is then added or subtracted as an unsigned number. A carry or a run of leading zeros is normalized away, and the fields are packed again. The result goes into an output register on the clock edge that samples the input strobe.

The block does not handle rounding modes, subnormals, NaN, infinity or exception flags. Discarded bits are truncated. An out-of-range exponent saturates.

Top module: `fpas_top`

## Requirements
- R1: Word layout, from the top bit down, is sign, then 8 exponent bits, then MAN_W mantissa bits. A word whose exponent field is 0 has the value zero, whatever its mantissa bits hold. Any other word has the value (-1)^s * 1.m * 2^(e-127).
- R2: With op_sub=0 the result is A+B. With op_sub=1 it is A-B, computed by inverting B's sign and adding.
- R3: The result sign is the sign of the operand with the larger magnitude. Magnitudes are compared by exponent first, then by significand, and A wins a tie. The sign of B used here is its sign after the R2 inversion.
- R4: The smaller operand's significand, with its hidden 1, is placed in a window of 2*(MAN_W+1) bits. It is shifted right by the exponent difference, and bits shifted past the window are lost. A difference of 2*(MAN_W+1) or more leaves the larger operand unchanged.
- R5: When the magnitude sum carries past the hidden-1 position, the exponent is increased by 1 and the mantissa is taken one place higher.
- R6: When a subtraction leaves leading zeros, the mantissa is shifted left until the leading 1 returns to the hidden position, and the exponent is decreased by the shift count.
- R7: A zero magnitude result is emitted as the all-zero word (+0). This covers exact cancellation and the sum of two zeros.
- R8: Mantissa bits below the result precision are dropped, which truncates the magnitude toward zero.
- R9: If the result exponent would exceed 255, the output is the sign followed by all-one exponent and mantissa fields. If it would fall to 0 or below, the output is +0.
- R10: out_valid follows in_valid one clock later. out_result loads only on a clock edge where in_valid is 1 and holds otherwise. Reset clears both to 0.
- R11: Adding or subtracting a zero B to a nonzero A returns A's word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| opnd_a | input | 1+8+MAN_W | Operand A, packed |
| opnd_b | input | 1+8+MAN_W | Operand B, packed |
| out_valid | output | 1 | Result register was loaded on the previous edge |
| out_result | output | 1+8+MAN_W | Packed registered result |

## Verification
The assertions assume that opnd_a, opnd_b and op_sub are known values on every edge where in_valid is high. They also assume that rst_n is released in step with the clock, so that the first edge after reset samples a defined in_valid. The bench drives all inputs on the falling edge and keeps in_valid low during reset. It holds the operands steady across each sampled edge. The random sweep draws operand B's exponent close to A's, so that cancellation and normalization paths are exercised under those same conditions.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

  // Operation select as seen on op_sub
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpas_op_e;

  // Normalization path chosen for a raw magnitude
  typedef enum logic [1:0] {
    NRM_ZERO  = 2'd0,
    NRM_CARRY = 2'd1,
    NRM_SHIFT = 2'd2
  } fpas_norm_e;

endpackage

// File: rtl/fpas_unpack.sv
module fpas_unpack #(
  parameter  int EXP_W = 8,
  parameter  int MAN_W = 7,
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int SW    = MAN_W + 1
) (
  input  logic [FW-1:0]    word,
  input  logic             flip,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [SW-1:0]    sig
);

  logic [MAN_W-1:0] frac;
  logic             is_zero;

  always_comb begin
    frac    = word[MAN_W-1:0];
    expo    = word[FW-2:MAN_W];
    is_zero = (expo == '0);
    sign    = word[FW-1] ^ flip;
    // hidden one restored; a zero exponent means the value zero
    sig     = is_zero ? '0 : {1'b1, frac};
  end

endmodule

// File: rtl/fpas_align.sv
module fpas_align #(
  parameter  int EXP_W = 8,
  parameter  int MAN_W = 7,
  localparam int SW    = MAN_W + 1,
  localparam int WW    = 2 * SW
) (
  input  logic             sign_a,
  input  logic [EXP_W-1:0] exp_a,
  input  logic [SW-1:0]    sig_a,
  input  logic             sign_b,
  input  logic [EXP_W-1:0] exp_b,
  input  logic [SW-1:0]    sig_b,
  output logic             big_sign,
  output logic [EXP_W-1:0] big_exp,
  output logic [WW:0]      raw
);

  logic             a_major;
  logic             minor_sign;
  logic [EXP_W-1:0] minor_exp;
  logic [EXP_W-1:0] gap;
  logic [SW-1:0]    sig_major;
  logic [SW-1:0]    sig_minor;
  logic [WW-1:0]    w_major;
  logic [WW-1:0]    w_minor;
  logic             opposite;

  always_comb begin
    // magnitude order: exponent first, then significand; ties keep A
    a_major    = (exp_a > exp_b) || ((exp_a == exp_b) && (sig_a >= sig_b));
    big_sign   = a_major ? sign_a : sign_b;
    big_exp    = a_major ? exp_a  : exp_b;
    sig_major  = a_major ? sig_a  : sig_b;
    minor_sign = a_major ? sign_b : sign_a;
    minor_exp  = a_major ? exp_b  : exp_a;
    sig_minor  = a_major ? sig_b  : sig_a;
    gap        = big_exp - minor_exp;

    w_major = {sig_major, {SW{1'b0}}};
    if (gap >= EXP_W'(WW)) begin
      w_minor = '0;
    end else begin
      w_minor = {sig_minor, {SW{1'b0}}} >> gap;
    end

    opposite = big_sign ^ minor_sign;
    if (opposite) begin
      raw = {1'b0, w_major} - {1'b0, w_minor};
    end else begin
      raw = {1'b0, w_major} + {1'b0, w_minor};
    end
  end

endmodule

// File: rtl/fpas_norm.sv
module fpas_norm
  import fpas_pkg::*;
#(
  parameter  int EXP_W = 8,
  parameter  int MAN_W = 7,
  localparam int SW    = MAN_W + 1,
  localparam int WW    = 2 * SW,
  localparam int LZW   = $clog2(WW + 1),
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int EWX   = EXP_W + 2
) (
  input  logic             sign_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [WW:0]      raw,
  output logic [FW-1:0]    word
);

  logic [LZW-1:0]   lz;
  logic             found;
  fpas_norm_e       act;
  logic [WW-1:0]    shl;
  logic [EWX-1:0]   e_calc;
  logic [MAN_W-1:0] man;
  logic             under;
  logic             over;

  // leading-zero count over the window below the carry bit
  always_comb begin
    lz    = LZW'(WW);
    found = 1'b0;
    for (int i = WW - 1; i >= 0; i--) begin
      if (!found && raw[i]) begin
        lz    = LZW'(WW - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    shl = raw[WW-1:0] << lz;
    if (raw == '0) begin
      act = NRM_ZERO;
    end else if (raw[WW]) begin
      act = NRM_CARRY;
    end else begin
      act = NRM_SHIFT;
    end

    case (act)
      NRM_CARRY: begin
        e_calc = {2'b00, exp_in} + EWX'(1);
        man    = MAN_W'(raw >> (WW - MAN_W));
      end
      NRM_SHIFT: begin
        e_calc = {2'b00, exp_in} - EWX'(lz);
        man    = MAN_W'(shl >> (WW - 1 - MAN_W));
      end
      default: begin
        e_calc = '0;
        man    = '0;
      end
    endcase

    under = e_calc[EWX-1] || (e_calc == '0);
    over  = !e_calc[EWX-1] && e_calc[EXP_W];

    if (act == NRM_ZERO || under) begin
      word = '0;
    end else if (over) begin
      word = {sign_in, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
    end else begin
      word = {sign_in, e_calc[EXP_W-1:0], man};
    end
  end

endmodule

// File: rtl/fpas_top.sv
module fpas_top
  import fpas_pkg::*;
#(
  parameter  int EXP_W = 8,
  parameter  int MAN_W = 7,
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int SW    = MAN_W + 1,
  localparam int WW    = 2 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_sub,
  input  logic [FW-1:0] opnd_a,
  input  logic [FW-1:0] opnd_b,
  output logic          out_valid,
  output logic [FW-1:0] out_result
);

  fpas_op_e         op_sel;
  logic             flip_b;
  logic             sa, sb, big_sign;
  logic [EXP_W-1:0] ea, eb, big_exp;
  logic [SW-1:0]    siga, sigb;
  logic [WW:0]      raw;
  logic [FW-1:0]    sum_word;
  logic             vld_d, vld_q;
  logic [FW-1:0]    res_d, res_q;

  assign op_sel = fpas_op_e'(op_sub);
  assign flip_b = (op_sel == OP_SUB);

  fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_a (
    .word(opnd_a), .flip(1'b0), .sign(sa), .expo(ea), .sig(siga)
  );

  fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_b (
    .word(opnd_b), .flip(flip_b), .sign(sb), .expo(eb), .sig(sigb)
  );

  fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .sign_a(sa), .exp_a(ea), .sig_a(siga),
    .sign_b(sb), .exp_b(eb), .sig_b(sigb),
    .big_sign(big_sign), .big_exp(big_exp), .raw(raw)
  );

  fpas_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .sign_in(big_sign), .exp_in(big_exp), .raw(raw), .word(sum_word)
  );

  // next state: load result only under the input strobe
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = sum_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

  // R10: strobe reaches the output one edge later
  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  // R7: exact cancellation yields +0
  assert_cancel_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && (opnd_a == opnd_b)) |=> (out_result == '0));

  // R7/R9: any zero-exponent output is the canonical +0 word
  assert_zero_canon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_result[FW-2:MAN_W] == '0)) |-> (out_result == '0));

  // R11: a zero B leaves a nonzero A untouched
  assert_zero_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opnd_b[FW-2:MAN_W] == '0) && (opnd_a[FW-2:MAN_W] != '0))
    |=> (out_result == $past(opnd_a)));

  // R3: like effective signs keep that sign
  assert_like_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opnd_a[FW-2:MAN_W] != '0) && (opnd_b[FW-2:MAN_W] != '0) &&
     (opnd_a[FW-1] == (opnd_b[FW-1] ^ op_sub)))
    |=> (out_result[FW-1] == $past(opnd_a[FW-1])));

endmodule

// File: tb/tb_fpas_top.sv
module tb_fpas_top;

  localparam int EW = 8;
  localparam int MW = 7;
  localparam int FW = 1 + EW + MW;
  localparam int SW = MW + 1;
  localparam int WW = 2 * SW;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          op_sub;
  logic [FW-1:0] opnd_a;
  logic [FW-1:0] opnd_b;
  logic          out_valid;
  logic [FW-1:0] out_result;

  int n_vec;
  int n_bad;

  fpas_top #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference built from the written requirements
  function automatic logic [FW-1:0] ref_calc(input logic [FW-1:0] a,
                                             input logic [FW-1:0] b,
                                             input logic sub);
    int     ea, eb, ebig, esml, d, e;
    longint sga, sgb, sbig, ssml, wb, ws, r, m;
    bit     sa, sb, pa, pbig, psml;
    ea = int'(a[FW-2:MW]);
    eb = int'(b[FW-2:MW]);
    sga = (ea == 0) ? 0 : ((longint'(1) << MW) | longint'(a[MW-1:0]));
    sgb = (eb == 0) ? 0 : ((longint'(1) << MW) | longint'(b[MW-1:0]));
    sa = a[FW-1];
    sb = b[FW-1] ^ sub;
    pa = (ea > eb) || (ea == eb && sga >= sgb);
    ebig = pa ? ea : eb;   esml = pa ? eb : ea;
    sbig = pa ? sga : sgb; ssml = pa ? sgb : sga;
    pbig = pa ? sa : sb;   psml = pa ? sb : sa;
    d  = ebig - esml;
    wb = sbig << SW;
    ws = (d >= WW) ? 0 : ((ssml << SW) >> d);
    r  = (pbig == psml) ? wb + ws : wb - ws;
    if (r == 0) return '0;
    if (r >= (longint'(1) << WW)) begin
      e = ebig + 1;
      m = (r >> (WW - MW)) & ((longint'(1) << MW) - 1);
    end else begin
      e = ebig;
      while (r < (longint'(1) << (WW - 1))) begin
        r = r << 1;
        e = e - 1;
      end
      m = (r >> (WW - 1 - MW)) & ((longint'(1) << MW) - 1);
    end
    if (e <= 0) return '0;
    if (e > 255) return {pbig, {EW{1'b1}}, {MW{1'b1}}};
    return {pbig, EW'(e), MW'(m)};
  endfunction

  task automatic apply(input logic [FW-1:0] a, input logic [FW-1:0] b,
                       input logic sub, output logic [FW-1:0] got,
                       output logic vgot);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got  = out_result;
    vgot = out_valid;
  endtask

  task automatic run_op(input string tag, input logic [FW-1:0] a,
                        input logic [FW-1:0] b, input logic sub,
                        input logic [FW-1:0] exp);
    logic [FW-1:0] got;
    logic          v;
    apply(a, b, sub, got, v);
    check({tag, " valid"}, {{(FW-1){1'b0}}, v}, {{(FW-1){1'b0}}, 1'b1});
    check(tag, got, exp);
    check({tag, " model"}, exp, ref_calc(a, b, sub));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0;
    opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {{(FW-1){1'b0}}, out_valid}, '0);
    check("R10 reset result", out_result, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic;
    run_op("R2 1+1", 16'h3F80, 16'h3F80, 1'b0, 16'h4000);
    run_op("R2 3-1", 16'h4040, 16'h3F80, 1'b1, 16'h4000);
    run_op("R5 1-(-1) carry", 16'h3F80, 16'hBF80, 1'b1, 16'h4000);
  endtask

  task automatic t_sign;
    run_op("R3 -3+1", 16'hC040, 16'h3F80, 1'b0, 16'hC000);
    run_op("R3 1-3", 16'h3F80, 16'h4040, 1'b1, 16'hC000);
    run_op("R3 -1-1", 16'hBF80, 16'h3F80, 1'b1, 16'hC000);
  endtask

  task automatic t_zero;
    run_op("R7 cancel", 16'h4040, 16'h4040, 1'b1, 16'h0000);
    run_op("R7 3+(-3)", 16'h4040, 16'hC040, 1'b0, 16'h0000);
    run_op("R7 -0+0", 16'h8000, 16'h0000, 1'b0, 16'h0000);
    run_op("R1 junk zero A", 16'h007F, 16'h4040, 1'b0, 16'h4040);
    run_op("R11 A+0", 16'hC123, 16'h0000, 1'b0, 16'hC123);
    run_op("R11 A-0", 16'h4567, 16'h805A, 1'b1, 16'h4567);
  endtask

  task automatic t_align;
    run_op("R4 gap 15 sub", 16'h3F80, 16'h3800, 1'b1, 16'h3F7F);
    run_op("R4 gap 16 sub", 16'h3F80, 16'h3780, 1'b1, 16'h3F80);
    run_op("R8 gap 7 keeps bit", 16'h3F80, 16'h3C00, 1'b0, 16'h3F81);
    run_op("R8 gap 9 truncated", 16'h3F80, 16'h3B00, 1'b0, 16'h3F80);
    run_op("R6 1.5-1.25", 16'h3FC0, 16'h3FA0, 1'b1, 16'h3E80);
  endtask

  task automatic t_sat;
    run_op("R9 overflow +", 16'h7F80, 16'h7F80, 1'b0, 16'h7FFF);
    run_op("R9 overflow -", 16'hFF80, 16'hFF80, 1'b0, 16'hFFFF);
    run_op("R9 underflow", 16'h0081, 16'h0080, 1'b1, 16'h0000);
  endtask

  task automatic t_timing;
    logic [FW-1:0] held;
    logic          v;
    apply(16'h4040, 16'h3F80, 1'b0, held, v);
    check("R10 loaded", held, 16'h4080);
    @(negedge clk);
    opnd_a = 16'h3F80; opnd_b = 16'h3F80; op_sub = 1'b0;
    check("R10 valid drops", {{(FW-1){1'b0}}, out_valid}, '0);
    check("R10 result holds", out_result, 16'h4080);
    @(negedge clk);
    check("R10 still holds", out_result, 16'h4080);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 400; k++) begin
      logic [FW-1:0] a, b, got;
      logic          s, v;
      logic [EW-1:0] eb;
      a  = FW'($urandom);
      eb = a[FW-2:MW] + EW'($urandom_range(0, 6)) - EW'(3);
      b  = {1'($urandom), eb, MW'($urandom)};
      s  = 1'($urandom);
      apply(a, b, s, got, v);
      check("R2 R6 sweep", got, ref_calc(a, b, s));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    t_reset();
    t_basic();
    t_sign();
    t_zero();
    t_align();
    t_sat();
    t_timing();
    t_sweep();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule